// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Controller

This block is the master side of a shared, asynchronous, multi-device processor bus. On behalf of a local client it bids for the bus on a request line that is star-wired to an arbiter. It accepts the grant and then runs read, write or vector cycles over a multiplexed address/data highway. The transfer itself is a fully interlocked handshake on three lines: cycle begin, cycle response and a cycle finished line that both ends may drive. Every protocol line is modelled as a pair: the value this block drives, and the wired-OR value it observes on the bus.

The client hands over one request at a time. A request carries a cycle kind, an address, a byte-mode code, write data and a retain flag. The block answers each request with exactly one status: done, refused or aborted. A read also returns its data. After a cycle the block keeps the bus for further cycles unless the arbiter asks for it back. A cycle marked retain keeps the bus even then, so that an indivisible sequence such as read-modify-write can follow. An active abort or bus reset line strips every cycle drive from the bus in the same clock.

Top module: `abus_master`

## Requirements
- R1: While `rst` is high at a clock edge, every bus drive output is low after that edge, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: `rq_o` rises only while the block does not hold the bus and both `bus_gnt_i` and `bus_reset_i` were low at the deciding edge. While `bus_reset_i` is high, a pending request is not bid for.
- R3: `acq_o` rises only after an edge at which all of the following held: `bus_gnt_i` high, `bus_rq_i` high, `rq_o` low, and cycle begin, response, finished, abort and reset all quiet. `rq_o` and `acq_o` are never high together.
- R4: Cycle begin is raised only while holding the bus, and only with the address and byte-mode lines driven. For a write (kind 1), cycle finished rises at least one clock before cycle begin. For a read (kind 0) or a vector (kind 2), cycle begin rises with cycle finished low.
- R5: Once cycle response is seen, the address is removed from the highway. A read then raises cycle finished and takes the slave's data, and the data is captured when cycle response returns low.
- R6: If `bus_gnt_i` is high while `bus_rq_i` is low during the address phase, the cycle ends with status 2 (refused), all drives are removed and `acq_o` falls.
- R7: In a write, the data is driven after the cycle is established. Cycle begin is released while the data is still driven. Cycle finished is released only after the data is removed and with abort quiet.
- R8: A read that completes reports status 1 (done) with the slave's data on `rsp_rdata_o`.
- R9: After a done cycle with retain clear, the bus is released once the arbiter has dropped `bus_rq_i`. With retain set, `acq_o` stays high in that case.
- R10: In any cycle where `bus_abort_i` or `bus_reset_i` is high, `cb_o`, `cf_o`, `hw_oe_o` and `bm_oe_o` are low in that same cycle. An interrupted cycle reports status 3 (aborted) and writes nothing.
- R11: Each accepted request gets exactly one one-cycle `rsp_valid_o` pulse with status 1, 2 or 3. `req_ready_o` is low from acceptance until that pulse.
- R12: A vector cycle passes only its address and reports status 1 with no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Client offers a request |
| req_ready_o | output | 1 | Request slot is free |
| req_kind_i | input | 2 | 0 read, 1 write, 2 vector |
| req_addr_i | input | 16 | Cycle address |
| req_bmode_i | input | 3 | Byte-mode / address-space code |
| req_wdata_i | input | 16 | Write data |
| req_retain_i | input | 1 | Keep the bus after this cycle |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 2 | 1 done, 2 refused, 3 aborted |
| rsp_rdata_o | output | 16 | Read data |
| bus_gnt_i | input | 1 | Observed bus-granted line |
| bus_rq_i | input | 1 | Observed own request line |
| bus_cb_i | input | 1 | Observed cycle begin |
| bus_cr_i | input | 1 | Observed cycle response |
| bus_cf_i | input | 1 | Observed cycle finished |
| bus_abort_i | input | 1 | Observed cycle abort |
| bus_reset_i | input | 1 | Observed bus reset |
| hw_i | input | 16 | Observed highway |
| rq_o | output | 1 | Drive of own request line |
| acq_o | output | 1 | Drive of bus-acquired |
| cb_o | output | 1 | Drive of cycle begin |
| cf_o | output | 1 | Drive of cycle finished |
| hw_o | output | 16 | Highway drive value |
| hw_oe_o | output | 1 | Highway drive enable |
| bm_o | output | 3 | Byte-mode drive value |
| bm_oe_o | output | 1 | Byte-mode drive enable |

## Verification
The assertions watch the ordering rules on every clock. They cover the bid and acquire preconditions, request and acquired never being driven together, and cycle begin only rising while the bus is held with the address out. They also cover a write marking cycle finished first, the same-cycle removal of all drives under abort or bus reset, and a legal status on every response. The bench scenarios are needed for whatever depends on a cooperating arbiter and slave. That covers the data the slave captures or returns, refusal by the arbiter, retain against hold release, bidding blocked by bus reset, and the count of one response per request.

// File: rtl/abm_pkg.sv
package abm_pkg;
    localparam int HW_W = 16;
    localparam int BM_W = 3;

    typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_VECTOR = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {ST_NONE = 2'd0, ST_DONE = 2'd1, ST_REFUSED = 2'd2, ST_ABORTED = 2'd3} stat_e;
    typedef enum logic [1:0] {HW_OFF, HW_ADDR, HW_DATA} hwsel_e;

    typedef enum logic [3:0] {
        S_IDLE, S_BID, S_ACQ, S_OWN, S_WCF, S_ADDR, S_WDAT,
        S_WCB, S_WFIN, S_RWT, S_REND, S_VWT, S_DONE
    } seq_e;

    typedef struct packed {
        kind_e            kind;
        logic [HW_W-1:0]  addr;
        logic [BM_W-1:0]  bmode;
        logic [HW_W-1:0]  wdata;
        logic             retain;
    } req_t;

    function automatic logic lines_quiet(input logic cb, input logic cr, input logic cf,
                                         input logic ab, input logic rs);
        return !(cb | cr | cf | ab | rs);
    endfunction

    function automatic logic in_cycle(input seq_e s);
        return (s == S_WCF) || (s == S_ADDR) || (s == S_WDAT) || (s == S_WCB) ||
               (s == S_WFIN) || (s == S_RWT) || (s == S_REND) || (s == S_VWT);
    endfunction
endpackage

// File: rtl/abm_req_slot.sv
module abm_req_slot
    import abm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  req_t req_in,
    input  logic take,
    output logic pend,
    output req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            req_q <= '0;
        end else if (take) begin
            pend <= 1'b0;
        end else if (load && !pend) begin
            pend  <= 1'b1;
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/abm_line_drv.sv
module abm_line_drv
    import abm_pkg::*;
(
    input  logic            kill,
    input  hwsel_e          hwsel,
    input  logic            cb_raw,
    input  logic            cf_raw,
    input  logic [HW_W-1:0] addr,
    input  logic [HW_W-1:0] wdata,
    input  logic [BM_W-1:0] bmode,
    output logic            cb_o,
    output logic            cf_o,
    output logic [HW_W-1:0] hw_o,
    output logic            hw_oe_o,
    output logic [BM_W-1:0] bm_o,
    output logic            bm_oe_o
);
    always_comb begin
        cb_o    = cb_raw & ~kill;
        cf_o    = cf_raw & ~kill;
        hw_o    = '0;
        hw_oe_o = 1'b0;
        bm_o    = '0;
        bm_oe_o = 1'b0;
        if (!kill) begin
            case (hwsel)
                HW_ADDR: begin
                    hw_o    = addr;
                    hw_oe_o = 1'b1;
                    bm_o    = bmode;
                    bm_oe_o = 1'b1;
                end
                HW_DATA: begin
                    hw_o    = wdata;
                    hw_oe_o = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/abm_seq.sv
module abm_seq
    import abm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pend,
    input  req_t            req,
    input  logic            gnt_i,
    input  logic            rq_i,
    input  logic            cb_i,
    input  logic            cr_i,
    input  logic            cf_i,
    input  logic            abort_i,
    input  logic            reset_i,
    input  logic [HW_W-1:0] hw_i,
    output logic            rq_o,
    output logic            acq_o,
    output logic            cb_raw,
    output logic            cf_raw,
    output hwsel_e          hwsel,
    output logic            take,
    output logic            rsp_valid,
    output stat_e           rsp_status,
    output logic [HW_W-1:0] rsp_rdata
);
    seq_e  st, nxt;
    logic  retain_q;
    logic  quiet;
    stat_e code;
    logic  cap;

    assign quiet = lines_quiet(cb_i, cr_i, cf_i, abort_i, reset_i);

    always_comb begin
        nxt  = st;
        code = ST_NONE;
        cap  = 1'b0;
        if (in_cycle(st) && (abort_i || reset_i)) begin
            nxt  = S_IDLE;
            code = ST_ABORTED;
        end else begin
            case (st)
                S_IDLE: if (pend && !gnt_i && !reset_i) nxt = S_BID;
                S_BID: begin
                    if (reset_i)            nxt = S_IDLE;
                    else if (gnt_i && rq_i) nxt = S_ACQ;
                end
                S_ACQ: begin
                    if (gnt_i && rq_i && quiet) nxt = S_OWN;
                    else if (!rq_i || reset_i)  nxt = S_IDLE;
                end
                S_OWN: begin
                    if (reset_i)                                      nxt = S_IDLE;
                    else if ((gnt_i && !pend) || (!rq_i && !retain_q)) nxt = S_IDLE;
                    else if (pend && quiet)
                        nxt = (req.kind == K_WRITE) ? S_WCF : S_ADDR;
                end
                S_WCF: begin
                    if (gnt_i && !rq_i) begin
                        nxt  = S_IDLE;
                        code = ST_REFUSED;
                    end else nxt = S_ADDR;
                end
                S_ADDR: begin
                    if (gnt_i && !rq_i) begin
                        nxt  = S_IDLE;
                        code = ST_REFUSED;
                    end else if (cr_i) begin
                        case (req.kind)
                            K_WRITE: nxt = S_WDAT;
                            K_READ:  nxt = S_RWT;
                            default: nxt = S_VWT;
                        endcase
                    end
                end
                S_WDAT: nxt = S_WCB;
                S_WCB:  if (!cr_i) nxt = S_WFIN;
                S_WFIN: nxt = S_DONE;
                S_RWT: begin
                    if (!cr_i) begin
                        cap = 1'b1;
                        nxt = S_REND;
                    end
                end
                S_REND: if (!cf_i) nxt = S_DONE;
                S_VWT:  if (!cr_i) nxt = S_DONE;
                S_DONE: nxt = S_OWN;
                default: nxt = S_IDLE;
            endcase
            if (nxt == S_DONE) code = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            retain_q   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_NONE;
            rsp_rdata  <= '0;
        end else begin
            st         <= nxt;
            rsp_valid  <= (code != ST_NONE);
            rsp_status <= code;
            if (cap) rsp_rdata <= hw_i;
            if (nxt == S_DONE)      retain_q <= req.retain;
            else if (nxt == S_IDLE) retain_q <= 1'b0;
        end
    end

    assign take = (code != ST_NONE);

    always_comb begin
        rq_o   = (st == S_BID);
        acq_o  = (st == S_OWN) || (st == S_DONE) || in_cycle(st);
        cb_raw = (st == S_ADDR) || (st == S_WDAT) || (st == S_RWT) || (st == S_VWT);
        cf_raw = (st == S_WCF) || (st == S_WDAT) || (st == S_WCB) || (st == S_WFIN) ||
                 (st == S_RWT) || ((st == S_ADDR) && (req.kind == K_WRITE));
        case (st)
            S_WCF, S_ADDR: hwsel = HW_ADDR;
            S_WDAT, S_WCB: hwsel = HW_DATA;
            default:       hwsel = HW_OFF;
        endcase
    end
endmodule

// File: rtl/abus_master.sv
module abus_master
    import abm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid_i,
    output logic            req_ready_o,
    input  logic [1:0]      req_kind_i,
    input  logic [HW_W-1:0] req_addr_i,
    input  logic [BM_W-1:0] req_bmode_i,
    input  logic [HW_W-1:0] req_wdata_i,
    input  logic            req_retain_i,
    output logic            rsp_valid_o,
    output logic [1:0]      rsp_status_o,
    output logic [HW_W-1:0] rsp_rdata_o,
    input  logic            bus_gnt_i,
    input  logic            bus_rq_i,
    input  logic            bus_cb_i,
    input  logic            bus_cr_i,
    input  logic            bus_cf_i,
    input  logic            bus_abort_i,
    input  logic            bus_reset_i,
    input  logic [HW_W-1:0] hw_i,
    output logic            rq_o,
    output logic            acq_o,
    output logic            cb_o,
    output logic            cf_o,
    output logic [HW_W-1:0] hw_o,
    output logic            hw_oe_o,
    output logic [BM_W-1:0] bm_o,
    output logic            bm_oe_o
);
    req_t   req_in, req_q;
    logic   pend, take, cb_raw, cf_raw;
    hwsel_e hwsel;
    stat_e  status;

    assign req_in      = '{kind: kind_e'(req_kind_i), addr: req_addr_i, bmode: req_bmode_i,
                           wdata: req_wdata_i, retain: req_retain_i};
    assign req_ready_o = !pend;

    abm_req_slot u_slot (
        .clk(clk), .rst(rst), .load(req_valid_i), .req_in(req_in),
        .take(take), .pend(pend), .req_q(req_q)
    );

    abm_seq u_seq (
        .clk(clk), .rst(rst), .pend(pend), .req(req_q),
        .gnt_i(bus_gnt_i), .rq_i(bus_rq_i), .cb_i(bus_cb_i), .cr_i(bus_cr_i),
        .cf_i(bus_cf_i), .abort_i(bus_abort_i), .reset_i(bus_reset_i), .hw_i(hw_i),
        .rq_o(rq_o), .acq_o(acq_o), .cb_raw(cb_raw), .cf_raw(cf_raw), .hwsel(hwsel),
        .take(take), .rsp_valid(rsp_valid_o), .rsp_status(status), .rsp_rdata(rsp_rdata_o)
    );

    assign rsp_status_o = status;

    abm_line_drv u_drv (
        .kill(bus_abort_i | bus_reset_i), .hwsel(hwsel), .cb_raw(cb_raw), .cf_raw(cf_raw),
        .addr(req_q.addr), .wdata(req_q.wdata), .bmode(req_q.bmode),
        .cb_o(cb_o), .cf_o(cf_o), .hw_o(hw_o), .hw_oe_o(hw_oe_o),
        .bm_o(bm_o), .bm_oe_o(bm_oe_o)
    );
endmodule

// File: rtl/abus_master_chk.sv
module abus_master_chk
    import abm_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_ready_o,
    input logic            rsp_valid_o,
    input logic [1:0]      rsp_status_o,
    input logic            bus_gnt_i,
    input logic            bus_rq_i,
    input logic            bus_cb_i,
    input logic            bus_cr_i,
    input logic            bus_cf_i,
    input logic            bus_abort_i,
    input logic            bus_reset_i,
    input logic            rq_o,
    input logic            acq_o,
    input logic            cb_o,
    input logic            cf_o,
    input logic            hw_oe_o,
    input logic            bm_oe_o
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !rq_o && !acq_o && !cb_o && !cf_o && !hw_oe_o && !rsp_valid_o && req_ready_o);

    a_r2_bid_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(rq_o) |-> $past(!bus_gnt_i && !bus_reset_i && !acq_o));

    a_r3_acq_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_o) |-> $past(bus_gnt_i && bus_rq_i && !rq_o && !bus_cb_i && !bus_cr_i &&
                               !bus_cf_i && !bus_abort_i && !bus_reset_i));

    a_r3_no_rq_with_acq: assert property (@(posedge clk) disable iff (rst)
        !(rq_o && acq_o));

    a_r4_cb_needs_bus: assert property (@(posedge clk) disable iff (rst)
        $rose(cb_o) |-> acq_o && hw_oe_o && bm_oe_o);

    a_r4_write_cf_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(cb_o) && cf_o) |-> $past(cf_o));

    a_r10_kill_drives: assert property (@(posedge clk) disable iff (rst)
        (bus_abort_i || bus_reset_i) |-> !cb_o && !cf_o && !hw_oe_o && !bm_oe_o);

    a_r11_status_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> (rsp_status_o != 2'd0) && !$past(rsp_valid_o));
endmodule

bind abus_master abus_master_chk u_chk (.*);

// File: tb/abus_master_tb.sv
module abus_master_tb;
    localparam int HW = 16;
    localparam int BM = 3;

    typedef struct packed {
        logic [1:0]    kind;
        logic [HW-1:0] addr;
        logic [HW-1:0] wdata;
        logic          retain;
        logic [1:0]    mode;
        logic [1:0]    exp_st;
        logic [HW-1:0] exp_rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{kind: 2'd1, addr: 16'h0003, wdata: 16'hA5A5, retain: 1'b0, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'h0000},
        '{kind: 2'd0, addr: 16'h0003, wdata: 16'h0000, retain: 1'b0, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'hA5A5},
        '{kind: 2'd2, addr: 16'h0007, wdata: 16'h0000, retain: 1'b0, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'h0000},
        '{kind: 2'd1, addr: 16'h0005, wdata: 16'h1234, retain: 1'b1, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'h0000},
        '{kind: 2'd0, addr: 16'h0005, wdata: 16'h0000, retain: 1'b1, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'h1234},
        '{kind: 2'd0, addr: 16'h0009, wdata: 16'h0000, retain: 1'b0, mode: 2'd1, exp_st: 2'd2, exp_rd: 16'h0000},
        '{kind: 2'd1, addr: 16'h0002, wdata: 16'hBEEF, retain: 1'b0, mode: 2'd2, exp_st: 2'd3, exp_rd: 16'h0000},
        '{kind: 2'd0, addr: 16'h0002, wdata: 16'h0000, retain: 1'b0, mode: 2'd0, exp_st: 2'd1, exp_rd: 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0, req_ready, req_retain = 1'b0;
    logic [1:0]    req_kind = '0, rsp_status;
    logic [HW-1:0] req_addr = '0, req_wdata = '0, rsp_rdata, hw_o, hw_i;
    logic [BM-1:0] req_bmode = '0, bm_o;
    logic          rsp_valid, rq_o, acq_o, cb_o, cf_o, hw_oe_o, bm_oe_o;

    logic gnt = 1'b0, arb_rq = 1'b0, owner = 1'b0, refusing = 1'b0, arb_rel = 1'b0;
    logic cr = 1'b0, scf = 1'b0, sdrv = 1'b0, abort_l = 1'b0, breset = 1'b0;
    logic [HW-1:0] sdata = '0;
    logic [1:0] mode = 2'd0;

    logic [HW-1:0] mem [16];
    logic [HW-1:0] s_addr, s_wdata;
    logic [BM-1:0] s_bm;
    logic s_wr, s_vec, kill_ok, kill_chk;
    int   sl, ab_cnt;

    int checks = 0, errors = 0, n_req = 0, n_rsp = 0;

    abus_master u_dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_kind_i(req_kind), .req_addr_i(req_addr), .req_bmode_i(req_bmode),
        .req_wdata_i(req_wdata), .req_retain_i(req_retain),
        .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
        .bus_gnt_i(gnt), .bus_rq_i(rq_o | arb_rq), .bus_cb_i(cb_o), .bus_cr_i(cr),
        .bus_cf_i(cf_o | scf), .bus_abort_i(abort_l), .bus_reset_i(breset), .hw_i(hw_i),
        .rq_o(rq_o), .acq_o(acq_o), .cb_o(cb_o), .cf_o(cf_o), .hw_o(hw_o),
        .hw_oe_o(hw_oe_o), .bm_o(bm_o), .bm_oe_o(bm_oe_o)
    );

    assign hw_i = sdrv ? sdata : (hw_oe_o ? hw_o : '0);

    // arbiter and slave model, updated away from the active edge
    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        sl = 0; ab_cnt = 0; kill_chk = 1'b0; kill_ok = 1'b0;
        s_addr = '0; s_wdata = '0; s_bm = '0; s_wr = 1'b0; s_vec = 1'b0;
        forever begin
            @(negedge clk);
            if (owner && !acq_o) begin
                owner = 1'b0; arb_rq = 1'b0; gnt = 1'b0; refusing = 1'b0; arb_rel = 1'b0;
            end
            if (acq_o) begin
                owner = 1'b1;
                if (!refusing) gnt = 1'b0;
                if (arb_rel) arb_rq = 1'b0;
            end
            if (!owner && !gnt && rq_o) begin
                gnt = 1'b1; arb_rq = 1'b1;
            end
            if (!owner && gnt && !rq_o && !arb_rq) gnt = 1'b0;
            case (sl)
                0: if (cb_o) begin
                    s_addr = hw_o; s_bm = bm_o; s_wr = cf_o;
                    if (mode == 2'd2) begin
                        abort_l = 1'b1; ab_cnt = 2; sl = 4; kill_chk = 1'b1;
                    end else if (mode == 2'd1) begin
                        gnt = 1'b1; arb_rq = 1'b0; refusing = 1'b1; sl = 5;
                    end else begin
                        cr = 1'b1; sl = 1;
                    end
                end
                1: begin
                    if (s_wr) begin
                        if (!cb_o && hw_oe_o) begin
                            s_wdata = hw_o; mem[s_addr[3:0]] = hw_o; cr = 1'b0; sl = 3;
                        end
                    end else if (!hw_oe_o && cf_o) begin
                        sdata = mem[s_addr[3:0]]; sdrv = 1'b1; scf = 1'b1; sl = 2;
                    end else if (!hw_oe_o && !cf_o) begin
                        s_vec = 1'b1; cr = 1'b0; sl = 3;
                    end
                end
                2: begin cr = 1'b0; sl = 6; end
                6: if (!cb_o) begin sdrv = 1'b0; scf = 1'b0; sl = 3; end
                3: if (!cb_o && !cf_o) sl = 0;
                4: if (ab_cnt == 0) begin abort_l = 1'b0; sl = 3; end else ab_cnt = ab_cnt - 1;
                5: if (!cb_o) sl = 0;
                default: sl = 0;
            endcase
            if (kill_chk) begin
                #1;
                kill_ok = !cb_o && !cf_o && !hw_oe_o && !bm_oe_o;
                kill_chk = 1'b0;
            end
        end
    end

    always @(negedge clk) if (!rst && rsp_valid) n_rsp++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [1:0]    got_st;
    logic [HW-1:0] got_rd;

    task automatic issue(input logic [1:0] k, input logic [HW-1:0] a, input logic [BM-1:0] b,
                         input logic [HW-1:0] d, input logic ret);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_bmode = b; req_wdata = d; req_retain = ret;
        @(negedge clk);
        req_valid = 1'b0;
        n_req++;
    endtask

    task automatic wait_rsp(input string req);
        int n = 0;
        got_st = 2'd0; got_rd = '0;
        while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
        if (rsp_valid) begin got_st = rsp_status; got_rd = rsp_rdata; end
        else check({req, " timeout"}, 32'd0, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 drives", {27'd0, rq_o, acq_o, cb_o, cf_o, hw_oe_o}, 32'd0);
        check("R1 ready", {30'd0, req_ready, rsp_valid}, 32'd2);

        for (int i = 0; i < NV; i++) begin
            mode = VECS[i].mode;
            s_vec = 1'b0; kill_ok = 1'b0;
            issue(VECS[i].kind, VECS[i].addr, BM'(i), VECS[i].wdata, VECS[i].retain);
            check("R11 ready low while pending", {31'd0, req_ready}, 32'd0);
            wait_rsp("R11");
            check("R11 status", {30'd0, got_st}, {30'd0, VECS[i].exp_st});
            if (VECS[i].exp_st == 2'd1) begin
                check("R4 address seen", {16'd0, s_addr}, {16'd0, VECS[i].addr});
                check("R4 byte-mode seen", {29'd0, s_bm}, 32'(i));
            end
            if (VECS[i].kind == 2'd0 && VECS[i].exp_st == 2'd1)
                check("R8 R5 read data", {16'd0, got_rd}, {16'd0, VECS[i].exp_rd});
            if (VECS[i].kind == 2'd1 && VECS[i].exp_st == 2'd1)
                check("R7 write data", {16'd0, s_wdata}, {16'd0, VECS[i].wdata});
            if (VECS[i].kind == 2'd2)
                check("R12 vector no data", {31'd0, s_vec}, 32'd1);
            if (VECS[i].mode == 2'd1) begin
                repeat (3) @(negedge clk);
                check("R6 bus released", {30'd0, acq_o, cb_o}, 32'd0);
            end
            if (VECS[i].mode == 2'd2)
                check("R10 drives dropped", {31'd0, kill_ok}, 32'd1);
            repeat (4) @(negedge clk);
            mode = 2'd0;
        end

        // R9 retain keeps the bus after the arbiter drops the request
        issue(2'd1, 16'h0006, 3'd1, 16'h0F0F, 1'b1);
        wait_rsp("R9");
        check("R9 retained write", {30'd0, got_st}, 32'd1);
        arb_rel = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 retain holds bus", {31'd0, acq_o}, 32'd1);
        issue(2'd0, 16'h0006, 3'd2, 16'h0000, 1'b0);
        wait_rsp("R9");
        check("R9 hold read data", {16'd0, got_rd}, 32'h0F0F);
        repeat (6) @(negedge clk);
        check("R9 hold releases bus", {31'd0, acq_o}, 32'd0);

        // R2 no bid while bus reset is active
        breset = 1'b1;
        issue(2'd2, 16'h0001, 3'd0, 16'h0000, 1'b0);
        repeat (6) @(negedge clk);
        check("R2 no bid under reset", {30'd0, rq_o, acq_o}, 32'd0);
        breset = 1'b0;
        wait_rsp("R2");
        check("R2 bid after reset", {30'd0, got_st}, 32'd1);

        repeat (5) @(negedge clk);
        check("R11 one response per request", 32'(n_rsp), 32'(n_req));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule